// File: doc/BRIEF.md
# Presettable Binary Counter with Dual Enables

This block is a synchronous binary counter, four bits wide by default, and every state change happens on the rising clock edge. A clear input sets the count to zero. A load input copies a data word into the count. Two enable inputs must both be high for the count to advance. When either enable is low, the count holds its value.

A carry output shows that the counter sits at its all-ones terminal value, but only while the chaining enable is high. The local enable has no effect on the carry. Because of this, stages can be cascaded. The carry of a lower stage drives the chaining enable of the next stage up. Every stage gets the same local enable, clear and load. Two default-width stages chained this way count modulo 256.

Top module: `presettable_bin_counter`

## Requirements
- R1: When `clr_n` is low at a rising edge, the count becomes 0 after that edge, whatever the values of load and the enables.
- R2: When `clr_n` is high and `ld_n` is low at a rising edge, the count takes the value of `d_in` after that edge.
- R3: When `clr_n`, `ld_n`, `cnt_en_chain` and `cnt_en_local` are all high at a rising edge, the count increases by one.
- R4: When `clr_n` and `ld_n` are high and either enable is low at a rising edge, the count keeps its value.
- R5: `carry_out` is combinational and is high exactly when `cnt_en_chain` is high and the count is all ones (15 at the default width).
- R6: `cnt_en_local` has no effect on `carry_out`.
- R7: Counting from all ones wraps the count to 0.
- R8: When two instances are chained (the lower stage's `carry_out` drives the upper stage's `cnt_en_chain`, and all other inputs are shared), the pair counts modulo 256 at the default width, with the upper count as the high nibble.
- R9: A low `ld_n` takes priority over counting, even when both enables are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| cnt_en_chain | input | 1 | Count enable that also gates the carry |
| cnt_en_local | input | 1 | Count enable with no effect on the carry |
| d_in | input | W | Value to load |
| q | output | W | Current count |
| carry_out | output | 1 | Terminal count qualified by `cnt_en_chain` |

## Verification
Clear, load and count can all be requested at the same edge. The priority among them is the behaviour most likely to be wrong. The bench asserts clear while load is low and both enables are high, and expects zero. It then asserts load with both enables high and expects the loaded value, not that value plus one. A behavioural model runs beside the design under random control inputs that often overlap. The model compares the count and the carry on every clock, and a chained pair is checked against a counter modulo 256.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;

  // successor of a value held in w bits, wrapping to zero
  function automatic logic [31:0] cnt_succ(input logic [31:0] v, input int w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return (v + 32'd1) & mask;
  endfunction

  // all-ones test over the low w bits
  function automatic logic cnt_is_full(input logic [31:0] v, input int w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return (v & mask) == mask;
  endfunction

endpackage

// File: rtl/cnt_op_sel.sv
module cnt_op_sel
  import cnt_pkg::*;
(
  input  logic    clr_n,
  input  logic    ld_n,
  input  logic    en_chain,
  input  logic    en_local,
  output cnt_op_e op
);
  always_comb begin
    if (!clr_n)                      op = OP_CLEAR;
    else if (!ld_n)                  op = OP_LOAD;
    else if (en_chain && en_local)   op = OP_COUNT;
    else                             op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_state.sv
module cnt_state
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  cnt_op_e      op,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] succ;
  logic [31:0]  succ_wide;

  assign succ_wide = cnt_succ(32'(q), W);
  assign succ      = succ_wide[W-1:0];

  always_ff @(posedge clk) begin
    unique case (op)
      OP_CLEAR: q <= '0;
      OP_LOAD:  q <= d;
      OP_COUNT: q <= succ;
      default:  q <= q;
    endcase
  end
endmodule

// File: rtl/cnt_term.sv
module cnt_term
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] q,
  input  logic         en_chain,
  output logic         at_full,
  output logic         carry
);
  assign at_full = cnt_is_full(32'(q), W);
  assign carry   = en_chain & at_full;
endmodule

// File: rtl/presettable_bin_counter.sv
module presettable_bin_counter
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         cnt_en_chain,
  input  logic         cnt_en_local,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q,
  output logic         carry_out
);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  cnt_op_e op;
  logic    at_full;

  cnt_op_sel u_sel (
    .clr_n    (clr_n),
    .ld_n     (ld_n),
    .en_chain (cnt_en_chain),
    .en_local (cnt_en_local),
    .op       (op)
  );

  cnt_state #(.W(W)) u_state (
    .clk (clk),
    .op  (op),
    .d   (d_in),
    .q   (q)
  );

  cnt_term #(.W(W)) u_term (
    .q        (q),
    .en_chain (cnt_en_chain),
    .at_full  (at_full),
    .carry    (carry_out)
  );

  // count is unknown until the first clear; checks wait for it
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | ~clr_n;

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> q == '0);

  // R2 R9
  load_copy_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !ld_n) |=> q == $past(d_in));

  // R3
  count_inc_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ld_n && cnt_en_chain && cnt_en_local) |=> q == W'($past(q) + 1'b1));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ld_n && !(cnt_en_chain && cnt_en_local)) |=> $stable(q));

  // R5 R6
  carry_chk: assert property (@(posedge clk) disable iff (!armed)
    carry_out == (cnt_en_chain && (q == FULL)));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!armed)
    (op == OP_COUNT && at_full) |=> q == '0);

endmodule

// File: tb/tb_presettable_bin_counter.sv
`timescale 1ns/1ps
module tb_presettable_bin_counter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       clr_n, ld_n, en_chain, en_local;
  logic [3:0] d_in;
  logic [3:0] q;
  logic       carry_out;

  presettable_bin_counter #(.W(4)) dut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .cnt_en_chain(en_chain),
    .cnt_en_local(en_local), .d_in(d_in), .q(q), .carry_out(carry_out)
  );

  // chained pair
  logic       c_clr_n, c_ld_n, c_en;
  logic [3:0] lo_q, hi_q;
  logic       lo_carry, hi_carry;

  presettable_bin_counter #(.W(4)) u_lo (
    .clk(clk), .clr_n(c_clr_n), .ld_n(c_ld_n), .cnt_en_chain(1'b1),
    .cnt_en_local(c_en), .d_in(4'd0), .q(lo_q), .carry_out(lo_carry)
  );
  presettable_bin_counter #(.W(4)) u_hi (
    .clk(clk), .clr_n(c_clr_n), .ld_n(c_ld_n), .cnt_en_chain(lo_carry),
    .cnt_en_local(c_en), .d_in(4'd0), .q(hi_q), .carry_out(hi_carry)
  );

  int vectors = 0;
  int fails   = 0;
  int model   = 0;
  int cmodel  = 0;
  bit done    = 0;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: carry checked before the edge, count after it
  task automatic tick(input string req);
    int exp_c;
    #1;
    exp_c = (en_chain && model == 15) ? 1 : 0;
    check("R5 carry", int'(carry_out), exp_c);
    @(posedge clk);
    if (!clr_n)                  model = 0;
    else if (!ld_n)              model = int'(d_in);
    else if (en_chain && en_local) model = (model + 1) % 16;
    #1;
    check(req, int'(q), model);
  endtask

  task automatic drive(input logic c, input logic l, input logic et,
                       input logic ep, input logic [3:0] d);
    clr_n = c; ld_n = l; en_chain = et; en_local = ep; d_in = d;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    drive(1, 1, 0, 0, 4'd0);
    c_clr_n = 0; c_ld_n = 1; c_en = 0;
    @(negedge clk);
    // R1: clear beats load and counting
    drive(0, 0, 1, 1, 4'd9);
    tick("R1 clear priority");
    // R2/R9: load beats counting
    drive(1, 0, 1, 1, 4'd12);
    tick("R9 load over count");
    check("R2 preset 12", int'(q), 12);
    // R3: count 13,14,15
    drive(1, 1, 1, 1, 4'd0);
    tick("R3 count 13");
    tick("R3 count 14");
    tick("R3 count 15");
    // R6: local enable low, carry unchanged at full, count holds
    drive(1, 1, 1, 0, 4'd0);
    #1;
    check("R6 carry ignores local enable", int'(carry_out), 1);
    tick("R4 hold local low");
    // R7: wrap then 1,2
    drive(1, 1, 1, 1, 4'd0);
    tick("R7 wrap to 0");
    check("R7 wrapped", int'(q), 0);
    tick("R3 count 1");
    tick("R3 count 2");
    // R4: inhibit by chaining enable
    drive(1, 1, 0, 1, 4'd0);
    tick("R4 hold chain low");
    tick("R4 hold chain low");
    check("R4 held at 2", int'(q), 2);
    // carry gated by chain enable at full
    drive(1, 0, 0, 1, 4'd15);
    tick("R2 load 15");
    #1;
    check("R5 carry gated off", int'(carry_out), 0);
    // random overlap of controls
    for (int i = 0; i < 600; i++) begin
      drive(($urandom % 8) != 0, ($urandom % 6) != 0, ($urandom % 4) != 0,
            ($urandom % 3) != 0, 4'($urandom));
      tick("R1-R4 random mix");
    end
    // R8: chained pair modulo 256
    @(negedge clk);
    c_clr_n = 0;
    @(posedge clk);
    cmodel = 0;
    @(negedge clk);
    c_clr_n = 1; c_en = 1;
    for (int i = 0; i < 600; i++) begin
      if (i == 300) c_en = 0;
      if (i == 310) c_en = 1;
      @(posedge clk);
      if (c_en) cmodel = (cmodel + 1) % 256;
      #1;
      check("R8 cascade", int'(hi_q) * 16 + int'(lo_q), cmodel);
      @(negedge clk);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule